// File: doc/BRIEF.md
# Serial Byte Transmitter with Clear-to-Send Gating

This block turns bytes written by a host into asynchronous serial frames on one output line. The host writes a byte with a one-cycle write strobe. The byte waits in a one-entry holding register until the shift register can take it. A baud tick enable runs at sixteen times the bit rate. Each serial bit lasts sixteen ticks, and every event inside the block is placed at an exact tick count.

The frame has a low start bit, then 5 to 8 data bits sent least significant bit first. An even or odd parity bit may follow, and then one or two high stop bits. Frame options come from static configuration inputs and are captured when a byte moves into the shift register. An active-low clear-to-send input stops the move from the holding register into the shift register while it is high. Two status outputs show that the holding register is free and that the line has finished with nothing left to send.

A byte written while the line is idle starts after a fixed delay. A byte written early enough during a frame follows the previous frame with no gap. A byte written too late in the final stop bit falls back to the idle delay.

Top module: `uart_cts_tx`

## Requirements
- R1: After reset, `txd` is 1, `holdEmpty` is 1 and `txDone` is 1.
- R2: A frame is made of these bits in order, each lasting 16 ticks: a 0 start bit; N data bits, LSB first, where N = 5 + `cfgLen` (0..3 gives 5..8); a parity bit when `cfgParEn` is 1; and one stop bit (1), or two when `cfgTwoStop` is 1. The parity bit is the XOR of the N data bits, inverted when `cfgParOdd` is 1, so 0 selects even parity and 1 selects odd. Between frames the line stays at 1.
- R3: Idle case. The shift register is idle and `ctsN` is low. `holdEmpty` rises after the 4th tick that follows the write strobe, and `txd` falls to the start bit on the 5th tick. A tick in the same cycle as the strobe does not count.
- R4: Chained case. Ticks in a bit are numbered 1 to 16, and the last stop bit begins on tick 0 (its entry tick). A byte written with fewer than 12 ticks of the last stop bit elapsed, and with `ctsN` low at the 15th tick, is moved at the 15th tick, so `holdEmpty` rises then. Its start bit begins on the 16th tick.
- R5: A byte written after 12 or more ticks of the last stop bit is not chained. The line goes idle at the end of the stop bit. The R3 timing then counts from that point: `holdEmpty` rises on the 4th tick and the start bit begins on the 5th.
- R6: While `ctsN` is high and the line is idle, a pending byte stays in the holding register. Once `ctsN` goes low, `holdEmpty` rises on the 4th tick and the start bit begins on the 5th.
- R7: If `ctsN` is high at the 15th tick of the last stop bit, the pending byte is not chained. The line returns to idle and R6 applies.
- R8: `txDone` rises on the 11th tick of the last stop bit if `holdEmpty` is 1 at that time. It falls on a write strobe and when a byte moves into the shift register.
- R9: A write while the holding register is full replaces the pending byte, and `holdEmpty` stays 0. In the idle case the 4-tick count restarts from the new strobe.
- R10: `holdEmpty` is 0 in the cycle after any write strobe.
- R11: The frame options that apply to a byte are the ones present on the configuration inputs when that byte moves into the shift register. Later changes do not alter the frame already in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudTick | input | 1 | One-cycle enable at 16x the bit rate |
| wrStb | input | 1 | One-cycle write strobe for the holding register |
| wrData | input | 8 | Byte to write |
| cfgLen | input | 2 | Data length select, 0..3 gives 5..8 bits |
| cfgParEn | input | 1 | Adds a parity bit when 1 |
| cfgParOdd | input | 1 | Selects odd parity when 1, even when 0 |
| cfgTwoStop | input | 1 | Sends two stop bits when 1 |
| ctsN | input | 1 | Clear-to-send, active low; high blocks the move into the shift register |
| txd | output | 1 | Serial output line, idles high |
| holdEmpty | output | 1 | Holding register can take a byte |
| txDone | output | 1 | Line finished with no byte pending |

## Verification
The assertions assume only that every input is synchronous to `clk` and that reset is applied first. The design gates a move into the shift register whenever a write strobe is present, so a strobe and a tick in the same cycle leave the properties intact. The stimulus drives inputs on the falling clock edge. It places each tick as a lone one-cycle pulse with idle cycles around it, and it never lands a write or a `ctsN` change on a tick cycle. Each event therefore sits at an unambiguous tick position for the bench's expected values.

// File: rtl/uart_cts_tx_pkg.sv
package uart_cts_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP1,
    ST_STOP2
  } txState_t;

  typedef struct packed {
    logic capture;
    logic xfer;
    logic sendStart;
    logic sendData;
    logic sendParity;
    logic sendStop;
  } dpStrobe_t;

endpackage

// File: rtl/uart_cts_tx_ctrl.sv
module uart_cts_tx_ctrl
  import uart_cts_tx_pkg::*;
#(
  parameter int DATA_W          = 8,
  parameter int OSR             = 16,
  parameter int IDLE_XFER_TICKS = 4,
  parameter int DONE_TICK       = 11,
  parameter int LATE_TICK       = 12,
  parameter int CHAIN_TICK      = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       wrStb,
  input  logic [1:0] cfgLen,
  input  logic       cfgParEn,
  input  logic       cfgTwoStop,
  input  logic       ctsN,
  output dpStrobe_t  strb,
  output logic       holdEmpty,
  output logic       txDone,
  output txState_t   curState
);

  localparam int SUB_W    = $clog2(OSR);
  localparam int IDX_W    = $clog2(DATA_W);
  localparam int LAUNCH_W = $clog2(IDLE_XFER_TICKS + 1);
  localparam int MIN_BITS = DATA_W - 3;

  txState_t             state, nState;
  logic [SUB_W-1:0]     subCnt, nSub;
  logic [IDX_W-1:0]     bitIdx, nIdx;
  logic [LAUNCH_W-1:0]  launchCnt;
  logic [1:0]           lenL;
  logic                 parEnL, twoStopL;
  logic                 eligible;

  logic [IDX_W-1:0]     dataLast;
  logic                 bitEnd, lastStop, chainGo, idleGo, xferGo, doneHit;

  assign curState = state;

  always_comb begin
    dataLast = IDX_W'(MIN_BITS - 1) + IDX_W'(lenL);
    bitEnd   = (subCnt == SUB_W'(OSR - 1));
    lastStop = (state == ST_STOP2) || (state == ST_STOP1 && !twoStopL);
    chainGo  = baudTick && lastStop && (subCnt == SUB_W'(CHAIN_TICK - 1)) &&
               !holdEmpty && eligible && !ctsN && !wrStb;
    idleGo   = baudTick && (state == ST_IDLE) && !holdEmpty && !ctsN && !wrStb &&
               (launchCnt == LAUNCH_W'(IDLE_XFER_TICKS - 1));
    xferGo   = chainGo || idleGo;
    doneHit  = baudTick && lastStop && (subCnt == SUB_W'(DONE_TICK - 1));
  end

  always_comb begin
    strb         = '0;
    strb.capture = wrStb;
    strb.xfer    = xferGo;
    nState       = state;
    nSub         = subCnt;
    nIdx         = bitIdx;
    if (baudTick) begin
      case (state)
        ST_IDLE: begin
          if (idleGo) nState = ST_LOAD;
        end
        ST_LOAD: begin
          nState         = ST_START;
          nSub           = '0;
          strb.sendStart = 1'b1;
        end
        ST_START: begin
          if (bitEnd) begin
            nState        = ST_DATA;
            nSub          = '0;
            nIdx          = '0;
            strb.sendData = 1'b1;
          end else begin
            nSub = subCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (bitEnd) begin
            nSub = '0;
            if (bitIdx == dataLast) begin
              if (parEnL) begin
                nState          = ST_PARITY;
                strb.sendParity = 1'b1;
              end else begin
                nState        = ST_STOP1;
                strb.sendStop = 1'b1;
              end
            end else begin
              nIdx          = bitIdx + 1'b1;
              strb.sendData = 1'b1;
            end
          end else begin
            nSub = subCnt + 1'b1;
          end
        end
        ST_PARITY: begin
          if (bitEnd) begin
            nState        = ST_STOP1;
            nSub          = '0;
            strb.sendStop = 1'b1;
          end else begin
            nSub = subCnt + 1'b1;
          end
        end
        ST_STOP1, ST_STOP2: begin
          if (chainGo) begin
            nState = ST_LOAD;
          end else if (bitEnd) begin
            nSub   = '0;
            nState = lastStop ? ST_IDLE : ST_STOP2;
          end else begin
            nSub = subCnt + 1'b1;
          end
        end
        default: nState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      subCnt <= '0;
      bitIdx <= '0;
    end else begin
      state  <= nState;
      subCnt <= nSub;
      bitIdx <= nIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenL     <= '0;
      parEnL   <= 1'b0;
      twoStopL <= 1'b0;
    end else if (xferGo) begin
      lenL     <= cfgLen;
      parEnL   <= cfgParEn;
      twoStopL <= cfgTwoStop;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      launchCnt <= '0;
    end else if (wrStb || state != ST_IDLE || holdEmpty || ctsN) begin
      launchCnt <= '0;
    end else if (baudTick) begin
      launchCnt <= launchCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eligible <= 1'b0;
    end else if (wrStb) begin
      eligible <= !(lastStop && subCnt >= SUB_W'(LATE_TICK));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdEmpty <= 1'b1;
    end else if (wrStb) begin
      holdEmpty <= 1'b0;
    end else if (xferGo) begin
      holdEmpty <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txDone <= 1'b1;
    end else if (wrStb || xferGo) begin
      txDone <= 1'b0;
    end else if (doneHit && holdEmpty) begin
      txDone <= 1'b1;
    end
  end

  // R10: a write always leaves the holding register marked full
  a_r10_write_fills: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> !holdEmpty);

  // R3: the empty flag only rises as a result of a baud tick
  a_r3_empty_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdEmpty) |-> $past(baudTick));

  // R6: clear-to-send high keeps a pending byte parked while idle
  a_r6_cts_holds_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && ctsN && !wrStb) |=> $stable(holdEmpty));

  // R7: clear-to-send high in the last stop bit prevents chaining
  a_r7_cts_blocks_chain: assert property (@(posedge clk) disable iff (!rstN)
    (lastStop && ctsN && !holdEmpty && !wrStb) |=> !holdEmpty);

  // R8: completion only reported with nothing pending
  a_r8_done_needs_empty: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDone) |-> holdEmpty);

  // R4: the load slot lasts exactly one tick before the start bit
  a_r4_load_then_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD && baudTick) |=> (state == ST_START));

endmodule

// File: rtl/uart_cts_tx_dp.sv
module uart_cts_tx_dp
  import uart_cts_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        cfgLen,
  input  logic              cfgParOdd,
  output logic              txd
);

  localparam int MIN_BITS = DATA_W - 3;

  logic [DATA_W-1:0] holdReg, shiftReg, keepMask;
  logic              parBit, parNext, txdR;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      keepMask[i] = (i < (MIN_BITS + int'(cfgLen)));
    end
    parNext = (^(holdReg & keepMask)) ^ cfgParOdd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (strb.capture) begin
      holdReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      txdR     <= 1'b1;
    end else begin
      if (strb.xfer) begin
        shiftReg <= holdReg;
        parBit   <= parNext;
      end
      if (strb.sendStart) begin
        txdR <= 1'b0;
      end else if (strb.sendData) begin
        txdR     <= shiftReg[0];
        shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
      end else if (strb.sendParity) begin
        txdR <= parBit;
      end else if (strb.sendStop) begin
        txdR <= 1'b1;
      end
    end
  end

  assign txd = txdR;

endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
  import uart_cts_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        cfgLen,
  input  logic              cfgParEn,
  input  logic              cfgParOdd,
  input  logic              cfgTwoStop,
  input  logic              ctsN,
  output logic              txd,
  output logic              holdEmpty,
  output logic              txDone
);

  dpStrobe_t strb;
  txState_t  curState;

  uart_cts_tx_ctrl #(
    .DATA_W(DATA_W),
    .OSR   (OSR)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .baudTick  (baudTick),
    .wrStb     (wrStb),
    .cfgLen    (cfgLen),
    .cfgParEn  (cfgParEn),
    .cfgTwoStop(cfgTwoStop),
    .ctsN      (ctsN),
    .strb      (strb),
    .holdEmpty (holdEmpty),
    .txDone    (txDone),
    .curState  (curState)
  );

  uart_cts_tx_dp #(
    .DATA_W(DATA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .cfgLen   (cfgLen),
    .cfgParOdd(cfgParOdd),
    .txd      (txd)
  );

  // R2: the serial line only moves on a baud tick
  a_r2_txd_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !baudTick |=> $stable(txd));

  // R1: the line sits high whenever no frame is being shifted
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLE || curState == ST_LOAD) |-> txd);

endmodule

// File: tb/uart_cts_tx_tb_top.sv
module uart_cts_tx_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       wrStb = 1'b0;
  logic [7:0] wrData = '0;
  logic [4:0] cfgDrv = '0;   // {len[1:0], parEn, parOdd, twoStop}
  logic       ctsN = 1'b0;
  logic       txd, holdEmpty, txDone;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  uart_cts_tx dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .baudTick  (baudTick),
    .wrStb     (wrStb),
    .wrData    (wrData),
    .cfgLen    (cfgDrv[4:3]),
    .cfgParEn  (cfgDrv[2]),
    .cfgParOdd (cfgDrv[1]),
    .cfgTwoStop(cfgDrv[0]),
    .ctsN      (ctsN),
    .txd       (txd),
    .holdEmpty (holdEmpty),
    .txDone    (txDone)
  );

  function automatic int dataLen(logic [4:0] c);
    return 5 + int'(c[4:3]);
  endfunction

  function automatic int frameBits(logic [4:0] c);
    return 2 + dataLen(c) + int'(c[2]) + int'(c[0]);
  endfunction

  function automatic logic expBit(logic [7:0] d, logic [4:0] c, int b);
    int n = dataLen(c);
    logic p = c[1];
    for (int i = 0; i < n; i++) p = p ^ d[i];
    if (b == 0) return 1'b0;
    if (b <= n) return d[b-1];
    if (c[2] && b == n + 1) return p;
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doTick();
    baudTick = 1'b1;
    @(negedge clk);
    baudTick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic writeByte(input logic [7:0] d, input logic [4:0] c);
    wrStb  = 1'b1;
    wrData = d;
    cfgDrv = c;
    @(negedge clk);
    wrStb = 1'b0;
    @(negedge clk);
    chk(holdEmpty == 1'b0, "R10 holdEmpty after write", holdEmpty, 0);
  endtask

  // Idle launch: hold full, line idle, ctsN low; ends right after the start tick
  task automatic idleLaunch(input string req);
    for (int t = 1; t <= 5; t++) begin
      doTick();
      if (t < 4) begin
        chk(holdEmpty == 1'b0, {req, " holdEmpty before 4th tick"}, holdEmpty, 0);
        chk(txd == 1'b1, {req, " line high before start"}, txd, 1);
      end else if (t == 4) begin
        chk(holdEmpty == 1'b1, {req, " holdEmpty on 4th tick"}, holdEmpty, 1);
        chk(txd == 1'b1, {req, " line high on 4th tick"}, txd, 1);
        chk(txDone == 1'b0, "R8 txDone low after transfer", txDone, 0);
      end else begin
        chk(txd == 1'b0, {req, " start bit on 5th tick"}, txd, 0);
      end
    end
  endtask

  // Runs a frame that started at tick 0; optional write and ctsN rise inside it
  task automatic playFrame(input logic [7:0] d, input logic [4:0] c,
                           input int wrAt, input logic [7:0] nd, input logic [4:0] nc,
                           input int ctsAt, output bit chained, output bit pending);
    int  nb = frameBits(c);
    int  len = 16 * nb;
    int  lastBase = 16 * (nb - 1);
    bit  expHe = 1'b1;
    bit  expDone = 1'b0;
    bit  full = 1'b0;
    bit  elig = 1'b0;
    logic expTx;
    chained = 1'b0;
    for (int j = 1; j <= len; j++) begin
      doTick();
      if (j == lastBase + 11 && !full) expDone = 1'b1;
      if (j == lastBase + 15 && full && elig && !ctsN) begin
        expHe = 1'b1;
        full = 1'b0;
        chained = 1'b1;
      end
      if (j < len) expTx = expBit(d, c, j / 16);
      else expTx = chained ? 1'b0 : 1'b1;
      chk(txd == expTx, "R2 frame bit (R4/R5/R7/R11)", txd, expTx);
      chk(holdEmpty == expHe, "R4 holdEmpty in frame (R5/R7/R9)", holdEmpty, expHe);
      chk(txDone == expDone, "R8 txDone in frame", txDone, expDone);
      if (j == 1) cfgDrv = 5'($urandom);
      if (j == wrAt) begin
        writeByte(nd, nc);
        full = 1'b1;
        expHe = 1'b0;
        expDone = 1'b0;
        elig = (j <= lastBase + 11);
      end
      if (j == ctsAt) ctsN = 1'b1;
    end
    pending = full;
  endtask

  // Plays a frame, then launches a pending byte if it was not chained.
  task automatic runChain(input logic [7:0] d, input logic [4:0] c, input int wrAt,
                          input logic [7:0] nd, input logic [4:0] nc, input int ctsAt,
                          output bit running);
    bit ch, pend;
    playFrame(d, c, wrAt, nd, nc, ctsAt, ch, pend);
    running = ch;
    if (!ch && pend) begin
      if (ctsN) begin
        for (int k = 0; k < 3; k++) begin
          doTick();
          chk(holdEmpty == 1'b0, "R7 byte held while ctsN high", holdEmpty, 0);
          chk(txd == 1'b1, "R7 line idle while ctsN high", txd, 1);
        end
        ctsN = 1'b0;
        idleLaunch("R6");
      end else begin
        idleLaunch("R5");
      end
      running = 1'b1;
    end
  endtask

  initial begin
    #(20ns * 190000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] cd, nd;
    logic [4:0] cc, nc;
    bit running;
    int nb, wa, ca, mode;
    void'($urandom(32'd5150));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R1 reset txd", txd, 1);
    chk(holdEmpty == 1'b1, "R1 reset holdEmpty", holdEmpty, 1);
    chk(txDone == 1'b1, "R1 reset txDone", txDone, 1);

    // R3 idle start, 8N1, then R4 boundary chain at tick 11 of last stop
    cc = 5'b11000; cd = 8'hA5;
    writeByte(cd, cc);
    idleLaunch("R3");
    nb = frameBits(cc);
    nc = 5'b01110; nd = 8'h3C;
    runChain(cd, cc, 16 * (nb - 1) + 11, nd, nc, -1, running);
    cd = nd; cc = nc; nb = frameBits(cc);
    // R5 late write exactly at tick 12 of last stop
    nc = 5'b10101; nd = 8'hC3;
    runChain(cd, cc, 16 * (nb - 1) + 12, nd, nc, -1, running);
    cd = nd; cc = nc; nb = frameBits(cc);
    // R7 chain blocked by ctsN raised before the 15th tick
    nc = 5'b00100; nd = 8'h5A;
    runChain(cd, cc, 20, nd, nc, 16 * (nb - 1) + 13, running);
    cd = nd; cc = nc;
    runChain(cd, cc, -1, 8'h00, 5'b0, -1, running);

    // R6 ctsN high holds an idle byte
    ctsN = 1'b1;
    writeByte(8'h96, 5'b11100);
    for (int k = 0; k < 8; k++) begin
      doTick();
      chk(holdEmpty == 1'b0, "R6 held by ctsN", holdEmpty, 0);
      chk(txd == 1'b1, "R6 line idle", txd, 1);
    end
    // R9 overwrite while held
    writeByte(8'h69, 5'b11010);
    chk(holdEmpty == 1'b0, "R9 overwrite keeps flag clear", holdEmpty, 0);
    ctsN = 1'b0;
    idleLaunch("R6");
    runChain(8'h69, 5'b11010, -1, 8'h00, 5'b0, -1, running);

    // R9 overwrite restarts the idle count
    writeByte(8'h0F, 5'b11000);
    doTick();
    doTick();
    writeByte(8'hF0, 5'b01001);
    idleLaunch("R9");
    runChain(8'hF0, 5'b01001, -1, 8'h00, 5'b0, -1, running);

    // Random frames, R11 covered by configuration scrambling inside frames
    cd = 8'($urandom); cc = 5'($urandom);
    writeByte(cd, cc);
    idleLaunch("R3");
    for (int it = 0; it < 40; it++) begin
      nb = frameBits(cc);
      nd = 8'($urandom); nc = 5'($urandom);
      mode = int'($urandom % 4);
      wa = -1; ca = -1;
      if (mode == 1) wa = 1 + int'($urandom % (16 * (nb - 1) + 11));
      if (mode == 2) wa = 16 * (nb - 1) + 12 + int'($urandom % 4);
      if (mode == 3) begin
        wa = 1 + int'($urandom % (16 * (nb - 1) + 11));
        ca = 16 * (nb - 1) + 13;
      end
      runChain(cd, cc, wa, nd, nc, ca, running);
      if (running) begin
        cd = nd; cc = nc;
      end else begin
        cd = 8'($urandom); cc = 5'($urandom);
        writeByte(cd, cc);
        idleLaunch("R3");
      end
    end
    runChain(cd, cc, -1, 8'h00, 5'b0, -1, running);

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule